// File: doc/BRIEF.md
# Accumulator and Index Register Transfer Unit

This block is the register-transfer and flag core of a small 8-bit accumulator machine. It holds the accumulator, a 16-bit index pair (high byte and low byte X), a 16-bit stack pointer and a condition code register with overflow, half-carry, interrupt-mask, negative, zero and carry bits. Each accepted one-byte opcode is decoded and executed against those registers. The operation may be a subtract, a test, a store of X, or one of several register transfers. The flags are then updated by the fixed rule that belongs to that opcode.

A memory operand arrives on `mem_in` together with the opcode. Store data leaves on `st_data_o`, marked by a one-cycle `st_en_o` strobe. Address generation, fetch and bus timing belong to the surrounding machine. Two transfers need a second cycle; during that cycle `op_ready` is low and any offered opcode is dropped. An opcode outside the supported set leaves all state alone and raises `illegal_o` for one cycle.

Top module: `axr_unit`

## Requirements
- R1: After reset, the accumulator is 0x00, the index pair is 0x0000, the stack pointer is 0x00FF, `op_ready` is 1, and `st_en_o`, `illegal_o` and `st_data_o` are 0. The condition code image on `ccr_o` is 0x68. Its bit layout, most significant bit first, is V, 1, 1, H, I, N, Z, C.
- R2: Opcode 0xA0 writes accumulator minus `mem_in` (modulo 256) into the accumulator. C is set on an unsigned borrow. V is set when the operand signs differ and the result sign differs from the old accumulator sign. N takes result bit 7, and Z is set for a zero result. H and I are kept.
- R3: Opcodes 0x4D (accumulator), 0x5D (X) and 0x3D (`mem_in`) test their operand and write no register. V is cleared, N and Z follow the operand, and C, H and I are kept.
- R4: Opcode 0xBF drives X on `st_data_o` with `st_en_o` high for exactly the next cycle. V is cleared, N and Z follow X, and H, I and C are kept.
- R5: Opcode 0x84 loads every flag from the accumulator, using the R1 layout, with bits 6 and 5 reading as one. It completes one cycle after the next clock edge, and `op_ready` is low for that single cycle. Opcode 0x85 copies `ccr_o` into the accumulator and changes no flag; it completes at the next edge.
- R6: Opcode 0x95 loads the index pair with the stack pointer plus one (16-bit wrap) and takes two cycles, like 0x84. Opcode 0x94 loads the stack pointer with the index pair minus one (16-bit wrap) in one cycle. Neither changes a flag.
- R7: Opcode 0x97 copies the accumulator into X and leaves the index high byte alone. Opcode 0x9F copies X into the accumulator. Neither changes a flag.
- R8: Any other opcode with `op_valid` high changes no register or flag and raises `illegal_o` for the following cycle only.
- R9: While `op_ready` is low, `op_valid` and `opcode` are ignored.
- R10: With `op_valid` low and no two-cycle operation pending, no register, flag or output changes, and `st_en_o` and `illegal_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode offered this cycle |
| opcode | input | 8 | One-byte opcode |
| mem_in | input | 8 | Memory operand for subtract and test |
| op_ready | output | 1 | Low during the second cycle of a two-cycle transfer |
| acc_o | output | 8 | Accumulator |
| hx_o | output | 16 | Index pair, high byte then X |
| sp_o | output | 16 | Stack pointer |
| ccr_o | output | 8 | Condition code image |
| st_data_o | output | 8 | Store data |
| st_en_o | output | 1 | Store strobe, one cycle |
| illegal_o | output | 1 | Unsupported opcode seen, one cycle |

## Verification
The subtract is driven with operand pairs that give a zero result, a borrow with a signed overflow (0x00 minus 0x80, 0x7F minus 0xFF), and long pseudo-random mixes. These separate the carry rule from the overflow rule and each of them from N and Z. Tests and stores are applied after flag states with C set, which shows that C is kept while V is forced clear. The stack transfers are tried around the 0x0000/0xFFFF boundary to expose the opposite one-step offsets. Opcodes are also offered during the busy cycle and unsupported codes are mixed in, so that dropped and illegal operations can be told apart from real ones.

// File: rtl/axr_pkg.sv
// Package: shared opcode values, operation kinds and the flag record
// for the transfer unit. Assumes an 8-bit data path and a 16-bit address.
package axr_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int CW = 8;

    localparam logic [7:0] OPC_SUB  = 8'hA0;
    localparam logic [7:0] OPC_TSTM = 8'h3D;
    localparam logic [7:0] OPC_TSTA = 8'h4D;
    localparam logic [7:0] OPC_TSTX = 8'h5D;
    localparam logic [7:0] OPC_STX  = 8'hBF;
    localparam logic [7:0] OPC_TAP  = 8'h84;
    localparam logic [7:0] OPC_TPA  = 8'h85;
    localparam logic [7:0] OPC_TSX  = 8'h95;
    localparam logic [7:0] OPC_TXS  = 8'h94;
    localparam logic [7:0] OPC_TAX  = 8'h97;
    localparam logic [7:0] OPC_TXA  = 8'h9F;

    // Bit positions inside the byte image of the flags
    localparam int BIT_V = 7;
    localparam int BIT_H = 4;
    localparam int BIT_I = 3;
    localparam int BIT_N = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;

    typedef enum logic [3:0] {
        K_NONE, K_SUB, K_TSTA, K_TSTX, K_TSTM, K_STX,
        K_TAP, K_TPA, K_TSX, K_TXS, K_TAX, K_TXA
    } op_kind_e;

    typedef struct packed {
        logic v;
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } flags_t;

    // Pack the flag record into its byte image; bits 6 and 5 read as one
    function automatic logic [CW-1:0] flags_to_byte(flags_t f);
        logic [CW-1:0] b;
        b = 8'h60;
        b[BIT_V] = f.v;
        b[BIT_H] = f.h;
        b[BIT_I] = f.i;
        b[BIT_N] = f.n;
        b[BIT_Z] = f.z;
        b[BIT_C] = f.c;
        return b;
    endfunction

    // Unpack a byte image into the flag record
    function automatic flags_t byte_to_flags(logic [CW-1:0] b);
        flags_t f;
        f.v = b[BIT_V];
        f.h = b[BIT_H];
        f.i = b[BIT_I];
        f.n = b[BIT_N];
        f.z = b[BIT_Z];
        f.c = b[BIT_C];
        return f;
    endfunction
endpackage

// File: rtl/axr_decode.sv
// Opcode decoder: maps a one-byte opcode to an operation kind, and flags
// whether it is supported and whether it needs a second cycle.
// Assumes the opcode is stable while op_valid is sampled.
module axr_decode
    import axr_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind,
    output logic       legal,
    output logic       two_cycle
);
    // Table lookup of the supported opcodes
    always_comb begin
        unique case (opcode)
            OPC_SUB:  kind = K_SUB;
            OPC_TSTM: kind = K_TSTM;
            OPC_TSTA: kind = K_TSTA;
            OPC_TSTX: kind = K_TSTX;
            OPC_STX:  kind = K_STX;
            OPC_TAP:  kind = K_TAP;
            OPC_TPA:  kind = K_TPA;
            OPC_TSX:  kind = K_TSX;
            OPC_TXS:  kind = K_TXS;
            OPC_TAX:  kind = K_TAX;
            OPC_TXA:  kind = K_TXA;
            default:  kind = K_NONE;
        endcase
    end

    // Legality and cycle count follow from the kind
    always_comb begin
        legal     = (kind != K_NONE);
        two_cycle = (kind == K_TAP) || (kind == K_TSX);
    end
endmodule

// File: rtl/axr_alu.sv
// Subtractor: computes minuend minus subtrahend and the four arithmetic
// flags. A test is done by passing zero as the subtrahend.
module axr_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         v,
    output logic         n,
    output logic         z,
    output logic         c
);
    logic [W:0] wide;

    // Widened difference gives the borrow out as its top bit
    always_comb begin
        wide = {1'b0, a} - {1'b0, b};
        res  = wide[W-1:0];
        c    = wide[W];
        v    = (a[W-1] ^ b[W-1]) & (a[W-1] ^ wide[W-1]);
        n    = wide[W-1];
        z    = (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/axr_flags.sv
// Flag update: picks the next flag record from the operation kind, the
// subtractor flags and the accumulator (for a load of all flags).
// Assumes kind is K_NONE when nothing executes this cycle.
module axr_flags
    import axr_pkg::*;
(
    input  op_kind_e        kind,
    input  flags_t          cur,
    input  logic [DW-1:0]   acc,
    input  logic            alu_v,
    input  logic            alu_n,
    input  logic            alu_z,
    input  logic            alu_c,
    output flags_t          nxt
);
    // Per-kind flag rule; unlisted kinds keep every flag
    always_comb begin
        nxt = cur;
        unique case (kind)
            K_SUB: begin
                nxt.v = alu_v;
                nxt.n = alu_n;
                nxt.z = alu_z;
                nxt.c = alu_c;
            end
            K_TSTA, K_TSTX, K_TSTM, K_STX: begin
                nxt.v = 1'b0;
                nxt.n = alu_n;
                nxt.z = alu_z;
            end
            K_TAP:   nxt = byte_to_flags(acc);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/axr_unit.sv
// Transfer unit top: holds accumulator, index pair, stack pointer and
// flags, accepts one opcode per cycle when ready, and executes it.
// Two-cycle kinds are parked for one cycle and then committed.
// Assumes mem_in is valid in the cycle its opcode is offered.
module axr_unit
    import axr_pkg::*;
#(
    parameter logic [15:0] SP_RST = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [7:0]    opcode,
    input  logic [7:0]    mem_in,
    output logic          op_ready,
    output logic [7:0]    acc_o,
    output logic [15:0]   hx_o,
    output logic [15:0]   sp_o,
    output logic [7:0]    ccr_o,
    output logic [7:0]    st_data_o,
    output logic          st_en_o,
    output logic          illegal_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [DW-1:0] acc_q;
    logic [AW-1:0] hx_q;
    logic [AW-1:0] sp_q;
    flags_t        flg_q;
    logic          busy_q;
    op_kind_e      pend_q;
    logic [DW-1:0] st_q;
    logic          st_en_q;
    logic          ill_q;

    op_kind_e      dec_kind;
    logic          dec_legal;
    logic          dec_two;
    op_kind_e      eff_kind;
    logic [DW-1:0] alu_a;
    logic [DW-1:0] alu_b;
    logic [DW-1:0] alu_res;
    logic          alu_v;
    logic          alu_n;
    logic          alu_z;
    logic          alu_c;
    flags_t        flg_nxt;

    axr_decode u_dec (
        .opcode    (opcode),
        .kind      (dec_kind),
        .legal     (dec_legal),
        .two_cycle (dec_two)
    );

    // Select what executes now: a parked kind, a one-cycle kind, or nothing
    always_comb begin
        if (busy_q)
            eff_kind = pend_q;
        else if (op_valid && !dec_two)
            eff_kind = dec_kind;
        else
            eff_kind = K_NONE;
    end

    // Route the operands for the subtractor (tests subtract zero)
    always_comb begin
        unique case (eff_kind)
            K_TSTX, K_STX: alu_a = hx_q[DW-1:0];
            K_TSTM:        alu_a = mem_in;
            default:       alu_a = acc_q;
        endcase
        alu_b = (eff_kind == K_SUB) ? mem_in : '0;
    end

    axr_alu #(.W(DW)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .res (alu_res),
        .v   (alu_v),
        .n   (alu_n),
        .z   (alu_z),
        .c   (alu_c)
    );

    axr_flags u_flg (
        .kind  (eff_kind),
        .cur   (flg_q),
        .acc   (acc_q),
        .alu_v (alu_v),
        .alu_n (alu_n),
        .alu_z (alu_z),
        .alu_c (alu_c),
        .nxt   (flg_nxt)
    );

    // Sequencing of the busy cycle and the one-cycle status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pend_q  <= K_NONE;
            st_en_q <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            st_en_q <= (eff_kind == K_STX);
            ill_q   <= 1'b0;
            if (busy_q) begin
                busy_q <= 1'b0;
                pend_q <= K_NONE;
            end else if (op_valid) begin
                if (!dec_legal) begin
                    ill_q <= 1'b1;
                end else if (dec_two) begin
                    busy_q <= 1'b1;
                    pend_q <= dec_kind;
                end
            end
        end
    end

    // Register writes for the executing kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            hx_q  <= '0;
            sp_q  <= SP_RST;
            flg_q <= byte_to_flags(8'h68);
            st_q  <= '0;
        end else begin
            unique case (eff_kind)
                K_SUB:   acc_q <= alu_res;
                K_TPA:   acc_q <= flags_to_byte(flg_q);
                K_TXA:   acc_q <= hx_q[DW-1:0];
                K_TAX:   hx_q[DW-1:0] <= acc_q;
                K_TSX:   hx_q <= sp_q + ONE;
                K_TXS:   sp_q <= hx_q - ONE;
                K_STX:   st_q <= hx_q[DW-1:0];
                default: ;
            endcase
            flg_q <= flg_nxt;
        end
    end

    // Drive the ports from state
    always_comb begin
        op_ready  = !busy_q;
        acc_o     = acc_q;
        hx_o      = hx_q;
        sp_o      = sp_q;
        ccr_o     = flags_to_byte(flg_q);
        st_data_o = st_q;
        st_en_o   = st_en_q;
        illegal_o = ill_q;
    end
endmodule

// File: rtl/axr_unit_chk.sv
// Checker: port-level properties of the transfer unit, bound to the top.
module axr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [7:0]  opcode,
    input logic        op_ready,
    input logic [7:0]  acc_o,
    input logic [15:0] hx_o,
    input logic [15:0] sp_o,
    input logic [7:0]  ccr_o,
    input logic [7:0]  st_data_o,
    input logic        st_en_o,
    input logic        illegal_o
);
    logic take;
    assign take = op_valid && op_ready;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |=> op_ready); // R5

    AST_STORE_X: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 8'hBF) |=> (st_en_o && st_data_o == $past(hx_o[7:0]))); // R4

    AST_SP_FROM_HX: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 8'h94) |=> (sp_o == $past(hx_o) - 16'd1)); // R6

    AST_HX_FROM_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 8'h95) |=> ##1 (hx_o == $past(sp_o, 2) + 16'd1)); // R6

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (acc_o == $past(acc_o) && hx_o == $past(hx_o)
                       && sp_o == $past(sp_o) && ccr_o == $past(ccr_o))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && !op_valid) |=> ($stable(acc_o) && $stable(hx_o) && $stable(sp_o)
                                     && $stable(ccr_o) && !st_en_o && !illegal_o)); // R10
endmodule

bind axr_unit axr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .op_ready  (op_ready),
    .acc_o     (acc_o),
    .hx_o      (hx_o),
    .sp_o      (sp_o),
    .ccr_o     (ccr_o),
    .st_data_o (st_data_o),
    .st_en_o   (st_en_o),
    .illegal_o (illegal_o)
);

// File: tb/axr_unit_bench.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks with hand-computed values.
module axr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  mem_in = 8'h00;
    logic        op_ready;
    logic [7:0]  acc_o;
    logic [15:0] hx_o;
    logic [15:0] sp_o;
    logic [7:0]  ccr_o;
    logic [7:0]  st_data_o;
    logic        st_en_o;
    logic        illegal_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    int m_a, m_hx, m_sp, m_ccr, m_st, m_sten, m_ill, m_busy, m_pend;

    always #5 clk = ~clk;

    axr_unit u_axr_unit (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .opcode (opcode),
        .mem_in (mem_in), .op_ready (op_ready), .acc_o (acc_o), .hx_o (hx_o),
        .sp_o (sp_o), .ccr_o (ccr_o), .st_data_o (st_data_o),
        .st_en_o (st_en_o), .illegal_o (illegal_o)
    );

    function automatic string req_of(logic [7:0] op);
        case (op)
            8'hA0: return "R2";
            8'h4D, 8'h5D, 8'h3D: return "R3";
            8'hBF: return "R4";
            8'h84, 8'h85: return "R5";
            8'h94, 8'h95: return "R6";
            8'h97, 8'h9F: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference: N/Z from a byte, V cleared, C/H/I kept
    task automatic model_test(int t);
        m_ccr = (m_ccr & 8'h79) | (((t >> 7) & 1) << 2) | ((t == 0) ? 2 : 0);
    endtask

    task automatic model_exec(int op, int m);
        int sa, sm, sd, diff, r, vf;
        case (op)
            8'hA0: begin
                diff = m_a - m;
                r = diff & 255;
                sa = (m_a > 127) ? m_a - 256 : m_a;
                sm = (m > 127) ? m - 256 : m;
                sd = sa - sm;
                vf = (sd < -128 || sd > 127) ? 1 : 0;
                m_ccr = (m_ccr & 8'h78) | (vf << 7) | (((r >> 7) & 1) << 2)
                        | ((r == 0) ? 2 : 0) | ((diff < 0) ? 1 : 0);
                m_a = r;
            end
            8'h4D: model_test(m_a);
            8'h5D: model_test(m_hx & 255);
            8'h3D: model_test(m);
            8'hBF: begin m_st = m_hx & 255; m_sten = 1; model_test(m_st); end
            8'h84, 8'h95: begin m_busy = 1; m_pend = op; end
            8'h85: m_a = m_ccr;
            8'h94: m_sp = (m_hx + 65535) % 65536;
            8'h97: m_hx = (m_hx & 16'hFF00) | m_a;
            8'h9F: m_a = m_hx & 255;
            default: m_ill = 1;
        endcase
    endtask

    // Reference model advance on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_hx = 0; m_sp = 16'h00FF; m_ccr = 8'h68; m_st = 0;
            m_sten = 0; m_ill = 0; m_busy = 0; m_pend = 0;
        end else begin
            m_sten = 0;
            m_ill = 0;
            if (m_busy != 0) begin
                if (m_pend == 8'h84) m_ccr = m_a | 8'h60;
                else m_hx = (m_sp + 1) % 65536;
                m_busy = 0;
            end else if (op_valid) begin
                model_exec(int'(opcode), int'(mem_in));
            end
        end
    end

    // Full-state comparison against the model on every falling edge
    always @(negedge clk) begin
        logic [58:0] act, expv;
        if (rst_n) begin
            act  = {op_ready, acc_o, hx_o, sp_o, ccr_o, st_data_o, st_en_o, illegal_o};
            expv = {(m_busy == 0), 8'(m_a), 16'(m_hx), 16'(m_sp), 8'(m_ccr),
                    8'(m_st), (m_sten != 0), (m_ill != 0)};
            checks++;
            if (act !== expv) begin
                failures++;
                $display("FAIL %s model compare act=%h exp=%h", cur_req, act, expv);
            end
        end
    end

    task automatic lit(string req, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s directed act=%h exp=%h", req, act, expv);
        end
    endtask

    // Drive one cycle of input, then return just after the falling edge
    task automatic step(logic v, logic [7:0] op, logic [7:0] m);
        if (v) cur_req = req_of(op);
        op_valid = v; opcode = op; mem_in = m;
        @(negedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    task automatic set_a(int val);
        step(1'b1, 8'hA0, 8'((m_a - val) & 255));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0] ops [12];
        ops = '{8'hA0, 8'h4D, 8'h5D, 8'h3D, 8'hBF, 8'h84, 8'h85, 8'h95,
                8'h94, 8'h97, 8'h9F, 8'h42};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        lit("R1", 16'(acc_o), 16'h0000);
        lit("R1", hx_o, 16'h0000);
        lit("R1", sp_o, 16'h00FF);
        lit("R1", 16'(ccr_o), 16'h0068);
        lit("R1", {13'd0, op_ready, st_en_o, illegal_o}, 16'h0004);
        // R2 borrow with signed overflow: 0x00 - 0x80
        step(1'b1, 8'hA0, 8'h80);
        lit("R2", 16'(acc_o), 16'h0080);
        lit("R2", 16'(ccr_o), 16'h00ED);
        // R2 zero result
        set_a(8'h05);
        step(1'b1, 8'hA0, 8'h05);
        lit("R2", 16'(ccr_o), 16'h006A);
        // R2 0x7F - 0xFF
        set_a(8'h7F);
        step(1'b1, 8'hA0, 8'hFF);
        lit("R2", 16'(acc_o), 16'h0080);
        lit("R2", 16'(ccr_o), 16'h00ED);
        // R7 copy accumulator into X
        step(1'b1, 8'h97, 8'h00);
        lit("R7", hx_o, 16'h0080);
        lit("R7", 16'(ccr_o), 16'h00ED);
        // R3 test X keeps C, clears V
        step(1'b1, 8'h5D, 8'h00);
        lit("R3", 16'(ccr_o), 16'h006D);
        step(1'b1, 8'h3D, 8'h00);
        lit("R3", 16'(ccr_o), 16'h006B);
        lit("R3", 16'(acc_o), 16'h0080);
        // R4 store X
        step(1'b1, 8'hBF, 8'h00);
        lit("R4", {7'd0, st_en_o, st_data_o}, 16'h0180);
        lit("R4", 16'(ccr_o), 16'h006D);
        step(1'b0, 8'h00, 8'h00);
        lit("R4", 16'(st_en_o), 16'h0000);
        // R6 index pair minus one into stack pointer
        step(1'b1, 8'h94, 8'h00);
        lit("R6", sp_o, 16'h007F);
        set_a(8'h10);
        step(1'b1, 8'h97, 8'h00);
        step(1'b1, 8'h95, 8'h00);
        lit("R6", {15'd0, op_ready}, 16'h0000);
        lit("R6", hx_o, 16'h0010);
        step(1'b0, 8'h00, 8'h00);
        lit("R6", hx_o, 16'h0080);
        // R6 wrap at 0x0000 / 0xFFFF
        set_a(8'h00);
        step(1'b1, 8'h97, 8'h00);
        step(1'b1, 8'h94, 8'h00);
        lit("R6", sp_o, 16'hFFFF);
        set_a(8'h07);
        step(1'b1, 8'h97, 8'h00);
        step(1'b1, 8'h95, 8'h00);
        step(1'b0, 8'h00, 8'h00);
        lit("R6", hx_o, 16'h0000);
        // R5 load all flags; R9 opcode offered during the busy cycle is dropped
        set_a(8'h9F);
        step(1'b1, 8'h84, 8'h00);
        step(1'b1, 8'h9F, 8'h00);
        lit("R9", 16'(acc_o), 16'h009F);
        lit("R5", 16'(ccr_o), 16'h00FF);
        set_a(8'h00);
        step(1'b1, 8'h84, 8'h00);
        step(1'b0, 8'h00, 8'h00);
        lit("R5", 16'(ccr_o), 16'h0060);
        step(1'b1, 8'h85, 8'h00);
        lit("R5", 16'(acc_o), 16'h0060);
        lit("R5", 16'(ccr_o), 16'h0060);
        // R8 unsupported opcode
        step(1'b1, 8'h00, 8'h00);
        lit("R8", 16'(illegal_o), 16'h0001);
        lit("R8", 16'(acc_o), 16'h0060);
        step(1'b0, 8'h00, 8'h00);
        lit("R8", 16'(illegal_o), 16'h0000);
        // R10 idle with a subtract opcode present but not valid
        cur_req = "R10";
        op_valid = 1'b0; opcode = 8'hA0; mem_in = 8'h33;
        @(negedge clk);
        #1;
        lit("R10", 16'(acc_o), 16'h0060);
        // Pseudo-random mix, compared by the model every cycle
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], ops[int'(lfsr[7:4]) % 12], lfsr[15:8]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule